// File: doc/BRIEF.md
# Per-Core Mailbox Register Bank

This block holds a bank of 32-bit message words, a fixed number per processor core. It is used for signalling between cores. A sender raises bits in a target word through a write-one-to-set window. The receiver clears the bits it has handled through a separate write-one-to-clear window, and it reads the word back through that same clear window. Word n belongs to core n / 4 and is slot n % 4 of that core, so n = core*4 + slot.

Every word drives one bit of a pending vector. That bit is high whenever the word holds any set bit. The pending vector goes to an interrupt router elsewhere, and enabling and routing are done there. The bus is a simple register port: one write strobe and one read strobe, which are never active together. It has a byte address, 32-bit write data and 32-bit read data that is registered.

Top module: `mbox_bank`

## Requirements
- R1: While reset is low at a clock edge, every word is cleared. The pending vector and the read data are zero after that edge.
- R2: A write to byte address 0x80 + 4*n ORs the write data into word n. The new value is visible from the next clock edge.
- R3: A write to byte address 0xC0 + 4*n clears, in word n, every bit that is 1 in the write data. All other bits of word n are kept.
- R4: A read of address 0xC0 + 4*n returns word n on the data output one cycle after the read strobe. In cycles that follow no read, the data output is zero.
- R5: A read of the set window (0x80 to 0xBF) returns zero. A read of any address outside both windows also returns zero.
- R6: A write to an address outside 0x80 to 0xFF changes no word.
- R7: Pending bit n equals the OR of all bits of word n, registered, so it changes one cycle after the word does.
- R8: A set or clear to word n = core*4 + slot changes only word n and pending bit n.
- R9: The two low address bits are ignored, so 0x83 selects the same word as 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mbox_pend | output | 16 | Per-word nonzero flags, bit n for word n |

## Verification
A write changes the word at the first clock edge after its strobe. The pending bit follows one edge later, two edges after the strobe. Read data appears one edge after the read strobe. The bench's reference model updates its word array, expected pending vector and expected read value at each rising edge, with those same lags. It compares both outputs with the model at every falling edge, so each result is checked in the exact cycle it is due. It never looks ahead or waits for a result to settle.

// File: rtl/mbox_pkg.sv
// Shared types for the mailbox bank.
// Assumes: nothing beyond the standard language.
package mbox_pkg;

    // Which address window a bus access falls into.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2
    } mbox_win_e;

endpackage

// File: rtl/mbox_decode.sv
// Address decoder: classifies a byte address as set window, clear window or
// neither, and extracts the word index. The two low address bits are dropped.
// Assumes: the two windows do not overlap and each fits in the address space.
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int                NUM_BOX  = 16,
    parameter int                ADDR_W   = 8,
    parameter int                IDX_W    = 4,
    parameter logic [ADDR_W-1:0] SET_BASE = 8'h80,
    parameter logic [ADDR_W-1:0] CLR_BASE = 8'hC0
) (
    input  logic [ADDR_W-1:0] addr,
    output mbox_win_e         win,
    output logic [IDX_W-1:0]  idx
);
    localparam int              WIN_BYTES = NUM_BOX * 4;
    localparam logic [ADDR_W:0] WIN_LIM   = (ADDR_W+1)'(WIN_BYTES);

    logic [ADDR_W:0] set_off;
    logic [ADDR_W:0] clr_off;
    logic            set_hit;
    logic            clr_hit;

    // Offsets into each window; the top bit flags an address below the base.
    always_comb begin
        set_off = {1'b0, addr} - {1'b0, SET_BASE};
        clr_off = {1'b0, addr} - {1'b0, CLR_BASE};
        set_hit = !set_off[ADDR_W] && (set_off < WIN_LIM);
        clr_hit = !clr_off[ADDR_W] && (clr_off < WIN_LIM);
    end

    // Window classification and word index.
    always_comb begin
        if (set_hit) begin
            win = WIN_SET;
            idx = set_off[IDX_W+1:2];
        end else if (clr_hit) begin
            win = WIN_CLR;
            idx = clr_off[IDX_W+1:2];
        end else begin
            win = WIN_NONE;
            idx = clr_off[IDX_W+1:2];
        end
    end
endmodule

// File: rtl/mbox_cell.sv
// One mailbox word with its registered nonzero flag.
// Assumes: set_en and clr_en are never high together (single bus port).
module mbox_cell #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              pend
);
    // Word storage: OR on set, AND-NOT on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr_en) begin
            value <= value & ~wdata;
        end else if (set_en) begin
            value <= value | wdata;
        end
    end

    // Pending flag, registered from the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            pend <= |value;
        end
    end
endmodule

// File: rtl/mbox_readmux.sv
// Registered read path: returns the addressed word for clear-window reads,
// and zero for every other read and in every cycle without a read.
// Assumes: box_flat packs word k at bits [k*DATA_W +: DATA_W].
module mbox_readmux
    import mbox_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_BOX = 16,
    parameter int IDX_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  mbox_win_e                 win,
    input  logic [IDX_W-1:0]          idx,
    input  logic [NUM_BOX*DATA_W-1:0] box_flat,
    output logic [DATA_W-1:0]         rdata
);
    logic [DATA_W-1:0] sel_word;

    // Select the addressed word.
    always_comb begin
        sel_word = box_flat[idx*DATA_W +: DATA_W];
    end

    // Capture read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en && (win == WIN_CLR)) begin
            rdata <= sel_word;
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/mbox_bank.sv
// Mailbox bank top: NUM_CORES x BOXES_PER_CORE words, word n = core*per + slot.
// Writes to the set window OR data in, writes to the clear window clear bits,
// reads of the clear window return the word. Pending bit n = word n nonzero.
// Assumes: bus_wr and bus_rd are never asserted in the same cycle.
module mbox_bank
    import mbox_pkg::*;
#(
    parameter int                NUM_CORES      = 4,
    parameter int                BOXES_PER_CORE = 4,
    parameter int                DATA_W         = 32,
    parameter int                ADDR_W         = 8,
    parameter logic [ADDR_W-1:0] SET_BASE       = 8'h80,
    parameter logic [ADDR_W-1:0] CLR_BASE       = 8'hC0
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_wr,
    input  logic                                bus_rd,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [DATA_W-1:0]                   bus_wdata,
    output logic [DATA_W-1:0]                   bus_rdata,
    output logic [NUM_CORES*BOXES_PER_CORE-1:0] mbox_pend
);
    localparam int NUM_BOX = NUM_CORES * BOXES_PER_CORE;
    localparam int IDX_W   = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1;

    mbox_win_e                 acc_win;
    logic [IDX_W-1:0]          acc_idx;
    logic [NUM_BOX*DATA_W-1:0] box_flat;

    mbox_decode #(
        .NUM_BOX (NUM_BOX),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .SET_BASE(SET_BASE),
        .CLR_BASE(CLR_BASE)
    ) u_decode (
        .addr(bus_addr),
        .win (acc_win),
        .idx (acc_idx)
    );

    for (genvar g = 0; g < NUM_BOX; g++) begin : g_box
        logic set_en;
        logic clr_en;

        // Per-word write enables from the decoded access.
        always_comb begin
            set_en = bus_wr && (acc_win == WIN_SET) && (acc_idx == IDX_W'(g));
            clr_en = bus_wr && (acc_win == WIN_CLR) && (acc_idx == IDX_W'(g));
        end

        mbox_cell #(
            .DATA_W(DATA_W)
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_en(set_en),
            .clr_en(clr_en),
            .wdata (bus_wdata),
            .value (box_flat[g*DATA_W +: DATA_W]),
            .pend  (mbox_pend[g])
        );
    end

    mbox_readmux #(
        .DATA_W (DATA_W),
        .NUM_BOX(NUM_BOX),
        .IDX_W  (IDX_W)
    ) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (bus_rd),
        .win     (acc_win),
        .idx     (acc_idx),
        .box_flat(box_flat),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/mbox_bank_chk.sv
// Assertion checker for mbox_bank, attached by bind. Decodes the bus on its
// own and relates the bus, the stored words and the outputs over time.
// Assumes: bus_wr and bus_rd are exclusive.
module mbox_bank_chk #(
    parameter int DATA_W   = 32,
    parameter int NUM_BOX  = 16,
    parameter int ADDR_W   = 8,
    parameter int SET_BASE = 'h80,
    parameter int CLR_BASE = 'hC0
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic                      bus_rd,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic [NUM_BOX-1:0]        mbox_pend,
    input logic [NUM_BOX*DATA_W-1:0] box_flat
);
    localparam int WIN = NUM_BOX * 4;

    function automatic logic [DATA_W-1:0] pick(input logic [NUM_BOX*DATA_W-1:0] f, input int k);
        return f[k*DATA_W +: DATA_W];
    endfunction

    int                 a_int;
    logic               set_hit;
    logic               clr_hit;
    int                 set_idx;
    int                 clr_idx;
    logic [NUM_BOX-1:0] nz;

    // Independent window decode and nonzero summary.
    always_comb begin
        a_int   = int'(bus_addr);
        set_hit = (a_int >= SET_BASE) && (a_int < SET_BASE + WIN);
        clr_hit = (a_int >= CLR_BASE) && (a_int < CLR_BASE + WIN);
        set_idx = set_hit ? (a_int - SET_BASE) / 4 : 0;
        clr_idx = clr_hit ? (a_int - CLR_BASE) / 4 : 0;
        for (int k = 0; k < NUM_BOX; k++) nz[k] = (pick(box_flat, k) != '0);
    end

    a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mbox_pend == '0) && (bus_rdata == '0));

    a_r2_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && set_hit) |=>
        ((pick(box_flat, $past(set_idx)) & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && clr_hit) |=> ((pick(box_flat, $past(clr_idx)) & $past(bus_wdata)) == '0));

    a_r4_read_word: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && clr_hit) |=> (bus_rdata == $past(pick(box_flat, clr_idx))));

    a_r5_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !clr_hit) |=> (bus_rdata == '0));

    a_r7_pend_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mbox_pend == $past(nz)));
endmodule

bind mbox_bank mbox_bank_chk #(
    .DATA_W  (DATA_W),
    .NUM_BOX (NUM_BOX),
    .ADDR_W  (ADDR_W),
    .SET_BASE(SET_BASE),
    .CLR_BASE(CLR_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .mbox_pend(mbox_pend),
    .box_flat (box_flat)
);

// File: tb/mbox_bank_tb_top.sv
// Bench: behavioural reference model updated at each rising edge, both
// outputs compared against it at every falling edge.
module mbox_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] mbox_pend;

    int nvec = 0;
    int nbad = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    string rd_tag = "R4";
    string rd_tag_q = "R1";
    string pend_tag = "R7";

    logic [31:0] ref_box [16];
    logic [15:0] exp_pend = '0;
    logic [31:0] exp_rdata = '0;

    always #5 clk = ~clk;

    mbox_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mbox_pend(mbox_pend)
    );

    function automatic logic [15:0] nz_of();
        logic [15:0] v;
        for (int k = 0; k < 16; k++) v[k] = (ref_box[k] != 0);
        return v;
    endfunction

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        int a;
        a = int'(bus_addr);
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) ref_box[k] <= '0;
            exp_pend  <= '0;
            exp_rdata <= '0;
            rd_tag_q  <= "R1";
        end else begin
            exp_pend  <= nz_of();
            exp_rdata <= (bus_rd && a >= 'hC0) ? ref_box[(a - 'hC0) / 4] : 32'h0;
            rd_tag_q  <= bus_rd ? rd_tag : "R4";
            if (bus_wr && a >= 'h80 && a < 'hC0)
                ref_box[(a - 'h80) / 4] <= ref_box[(a - 'h80) / 4] | bus_wdata;
            else if (bus_wr && a >= 'hC0)
                ref_box[(a - 'hC0) / 4] <= ref_box[(a - 'hC0) / 4] & ~bus_wdata;
        end
    end

    // Compare both outputs away from the active edge.
    always @(negedge clk) begin
        if (running) begin
            nvec++;
            if (mbox_pend !== exp_pend) begin
                nbad++;
                $display("FAIL %s pending actual=%h expected=%h", (rst_n ? pend_tag : "R1"), mbox_pend, exp_pend);
            end
            nvec++;
            if (bus_rdata !== exp_rdata) begin
                nbad++;
                $display("FAIL %s rdata actual=%h expected=%h", rd_tag_q, bus_rdata, exp_rdata);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string t);
        @(negedge clk);
        pend_tag = t; bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string t);
        @(negedge clk);
        rd_tag = t; bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int r;
        @(negedge clk);
        running = 1'b1;
        idle(3);                       // R1: reset state compared each cycle
        rst_n = 1'b1;
        idle(2);
        wr(8'h80, 32'h0000_00FF, "R2");   // R2 set word 0
        rd(8'hC0, "R2");
        wr(8'h80, 32'h0F00_0000, "R2");   // R2 OR accumulates
        rd(8'hC0, "R2");
        wr(8'hC0, 32'h0000_000F, "R3");   // R3 clear low nibble
        rd(8'hC0, "R3");
        wr(8'hB4, 32'hA5A5_0000, "R8");   // R8 core 3 slot 1 -> word 13
        rd(8'hF4, "R8");
        rd(8'hB4, "R5");                  // R5 set window reads zero
        rd(8'h00, "R5");
        rd(8'h40, "R5");
        wr(8'h40, 32'hFFFF_FFFF, "R6");   // R6 outside windows
        wr(8'h7C, 32'hFFFF_FFFF, "R6");
        for (int k = 0; k < 16; k++) rd(8'hC0 + 8'(4*k), "R6");
        wr(8'h87, 32'h0000_1000, "R9");   // R9 low bits ignored -> word 1
        rd(8'hC6, "R9");
        wr(8'hC5, 32'hFFFF_FFFF, "R9");
        rd(8'hC4, "R9");
        wr(8'hC0, 32'hFFFF_FFFF, "R7");   // R7 pending falls after full clear
        wr(8'hF4, 32'hFFFF_FFFF, "R7");
        idle(3);
        for (int k = 0; k < 16; k++) wr(8'h80 + 8'(4*k), 32'(k + 1) << k, "R8");
        for (int k = 0; k < 16; k++) rd(8'hC0 + 8'(4*k), "R4");
        for (int i = 0; i < 400; i++) begin
            r = $urandom;
            case (r % 4)
                0: wr(8'h70 + 8'($urandom % 144), $urandom, "R2");
                1: wr(8'hC0 + 8'($urandom % 64), $urandom, "R3");
                2: rd(8'h70 + 8'($urandom % 144), "R4");
                default: idle(1);
            endcase
        end
        idle(3);
        rst_n = 1'b0;                  // R1: reset again with words set
        idle(2);
        rst_n = 1'b1;
        idle(2);
        running = 1'b0;
        finish_run();
    end
endmodule